// File: doc/BRIEF.md
# SMBus Host-Notify Target Receiver

This block listens on a two-wire SMBus segment as a target and accepts notification messages that other bus masters send to the host. Clock and data are taken through a synchronizer and a short majority filter; the block then follows START and STOP conditions and shifts bytes on rising clock edges. Its only output onto the bus is an open-drain pull-down on the data line.

Two 7-bit addresses are programmable. The notify address claims write transfers and acknowledges them. In a claimed transfer the byte after the address carries the sending device's own address in its upper seven bits and one further bit in its lowest bit. Data bytes follow. If the sender's address has the 10-bit prefix form, one extra address byte comes before the data. The snoop address is only watched. It never acknowledges anything. It raises its own flag when a transfer to that address ends with STOP.

The captured fields are registered outputs. They change only at the STOP that completes a claimed transfer. The outputs have no valid/ready pair and apply no back-pressure. A later completed transfer overwrites the fields, whether or not the earlier values were read. The two sticky flags tell software that new values are present, and each flag is cleared by a one-cycle pulse on its clear input.

Top module: `smb_notify_rx`

## Requirements
- R1: After reset all captured fields are zero, both status flags are 0 and the data line is not pulled low.
- R2: An address byte whose upper seven bits equal `hs_addr` and whose bit 0 is 0 (write) claims the transfer. The block pulls SDA low in the acknowledge slot of that address byte and of each expected following byte.
- R3: A read (address bit 0 = 1) to `hs_addr`, or any address equal to neither configured address, gets no acknowledge. It changes no captured field and no flag.
- R4: In a claimed transfer, bits 7:1 of the first byte after the address go to `cap_dev_addr` and its bit 0 goes to `cap_cmd_lsb`.
- R5: When `cap_dev_addr` bits 6:2 equal 11110, the next byte is captured as `cap_ext_byte`. For any other address `cap_ext_byte` keeps its previous value.
- R6: The two data bytes arrive low byte first and appear as `cap_data` = {second, first}.
- R7: Captured fields update and `hs_sts` sets only at a STOP that follows the full set of expected bytes. Before that STOP the outputs hold their old values.
- R8: An address byte matching `snoop_addr` sets `snp_sts` at the following STOP, for reads and writes alike. It is never acknowledged.
- R9: If `snoop_addr` equals `hs_addr`, `snp_sts` is not set.
- R10: A repeated START, or a STOP before all expected bytes, ends the transfer without any capture or flag change.
- R11: Flags are sticky. A one-cycle high pulse on `hs_sts_clr` or `snp_sts_clr` clears its flag. A set in the same cycle wins over the clear.
- R12: `sda_drive_low` is asserted only during the acknowledge slot of a claimed transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_drive_low | output | 1 | 1 pulls the data line low (open-drain enable) |
| hs_addr | input | 7 | Notify target address (typical value 0001000) |
| snoop_addr | input | 7 | Monitored address (typical value 0001000) |
| hs_sts_clr | input | 1 | Clear pulse for `hs_sts` |
| snp_sts_clr | input | 1 | Clear pulse for `snp_sts` |
| cap_dev_addr | output | 7 | Sender device address from the first byte after the address |
| cap_cmd_lsb | output | 1 | Bit 0 of that same byte |
| cap_ext_byte | output | 8 | Second byte of a 10-bit sender address |
| cap_data | output | 16 | Data word, high byte in bits 15:8 |
| hs_sts | output | 1 | Sticky flag: a notify transfer was captured |
| snp_sts | output | 1 | Sticky flag: a transfer to the snoop address ended |

## Verification
The notify path is driven with a 7-bit sender, with a sender that has the 10-bit prefix, and again after the notify address is reprogrammed. This separates the shorter and longer byte layouts and shows that `cap_ext_byte` is held when the layout is short. A read to the notify address, a transfer to an unrelated address, and snoop reads and writes show that only a claimed write draws an acknowledge, and that snooping stays silent on the bus. A repeated START in the middle of the data bytes and an early STOP show that partial transfers leave every output untouched. The default setting, where both addresses are equal, shows that the snoop flag is suppressed.

// File: rtl/smb_notify_pkg.sv
package smb_notify_pkg;
  localparam int ADDR_W   = 7;
  localparam int BYTE_W   = 8;
  localparam int BITCNT_W = 4;
  localparam int BIDX_W   = 3;
  localparam logic [4:0] TEN_BIT_TAG = 5'b11110;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_BITS,
    PH_ACK
  } phase_e;

  function automatic logic is_ten_bit(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:ADDR_W-5] == TEN_BIT_TAG;
  endfunction
endpackage

// File: rtl/smb_glitch_filter.sv
module smb_glitch_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int TAPS        = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic clean
);
  localparam int CNT_W = $clog2(TAPS + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [TAPS-1:0]        hist_q;
  logic [CNT_W-1:0]       ones;
  logic                   vote;

  always_comb begin
    ones = '0;
    for (int i = 0; i < TAPS; i++) ones = ones + CNT_W'(hist_q[i]);
    vote = ones > CNT_W'(TAPS / 2);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      hist_q <= '1;
      clean  <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
      hist_q <= {hist_q[TAPS-2:0], sync_q[SYNC_STAGES-1]};
      clean  <= vote;
    end
  end
endmodule

// File: rtl/smb_bus_events.sv
module smb_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic start_evt,
  output logic stop_evt,
  output logic scl_rise,
  output logic scl_fall
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign start_evt = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_evt  = scl_f & scl_q & ~sda_q & sda_f;
  assign scl_rise  = scl_f & ~scl_q;
  assign scl_fall  = ~scl_f & scl_q;
endmodule

// File: rtl/smb_notify_core.sv
module smb_notify_core
  import smb_notify_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_f,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic [ADDR_W-1:0] hs_addr,
  input  logic [ADDR_W-1:0] snoop_addr,
  input  logic              hs_sts_clr,
  input  logic              snp_sts_clr,
  output logic              sda_drive_low,
  output logic [ADDR_W-1:0] cap_dev_addr,
  output logic              cap_cmd_lsb,
  output logic [BYTE_W-1:0] cap_ext_byte,
  output logic [2*BYTE_W-1:0] cap_data,
  output logic              hs_sts,
  output logic              snp_sts
);
  phase_e               phase;
  logic [BITCNT_W-1:0]  bit_cnt;
  logic [BYTE_W-2:0]    shreg;
  logic [BIDX_W-1:0]    byte_idx;
  logic                 claim, snp_hit, ten, got_all, ack_want;
  logic [ADDR_W-1:0]    tmp_dev;
  logic                 tmp_lsb;
  logic [BYTE_W-1:0]    tmp_ext, tmp_lo, tmp_hi;
  logic [BYTE_W-1:0]    rx_byte;
  logic                 byte_done, hs_set, snp_set;

  assign rx_byte   = {shreg, sda_f};
  assign byte_done = (phase == PH_BITS) && scl_rise && (bit_cnt == BITCNT_W'(BYTE_W-1));
  assign hs_set    = stop_evt && claim && got_all;
  assign snp_set   = stop_evt && snp_hit && (snoop_addr != hs_addr);

  // bit engine and transfer tracking
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase         <= PH_IDLE;
      bit_cnt       <= '0;
      shreg         <= '0;
      byte_idx      <= '0;
      claim         <= 1'b0;
      snp_hit       <= 1'b0;
      ten           <= 1'b0;
      got_all       <= 1'b0;
      ack_want      <= 1'b0;
      sda_drive_low <= 1'b0;
    end else if (start_evt) begin
      phase         <= PH_BITS;
      bit_cnt       <= '0;
      byte_idx      <= '0;
      claim         <= 1'b0;
      snp_hit       <= 1'b0;
      ten           <= 1'b0;
      got_all       <= 1'b0;
      ack_want      <= 1'b0;
      sda_drive_low <= 1'b0;
    end else if (stop_evt) begin
      phase         <= PH_IDLE;
      claim         <= 1'b0;
      snp_hit       <= 1'b0;
      got_all       <= 1'b0;
      ack_want      <= 1'b0;
      sda_drive_low <= 1'b0;
    end else begin
      case (phase)
        PH_BITS: begin
          if (scl_rise && bit_cnt < BITCNT_W'(BYTE_W)) begin
            shreg   <= rx_byte[BYTE_W-2:0];
            bit_cnt <= bit_cnt + 1'b1;
          end else if (scl_fall && bit_cnt == BITCNT_W'(BYTE_W)) begin
            phase         <= PH_ACK;
            sda_drive_low <= ack_want;
          end
          if (byte_done) begin
            if (byte_idx != BIDX_W'(5)) byte_idx <= byte_idx + 1'b1;
            if (byte_idx == '0) begin
              claim    <= (rx_byte[BYTE_W-1:1] == hs_addr) && !rx_byte[0];
              ack_want <= (rx_byte[BYTE_W-1:1] == hs_addr) && !rx_byte[0];
              snp_hit  <= (rx_byte[BYTE_W-1:1] == snoop_addr);
            end else begin
              ack_want <= claim && !got_all;
              if (claim && !got_all) begin
                case (byte_idx)
                  BIDX_W'(1): begin
                    tmp_dev <= rx_byte[BYTE_W-1:1];
                    tmp_lsb <= rx_byte[0];
                    ten     <= is_ten_bit(rx_byte[BYTE_W-1:1]);
                  end
                  BIDX_W'(2): begin
                    if (ten) tmp_ext <= rx_byte;
                    else     tmp_lo  <= rx_byte;
                  end
                  BIDX_W'(3): begin
                    if (ten) tmp_lo <= rx_byte;
                    else begin
                      tmp_hi  <= rx_byte;
                      got_all <= 1'b1;
                    end
                  end
                  default: begin
                    tmp_hi  <= rx_byte;
                    got_all <= 1'b1;
                  end
                endcase
              end
            end
          end
        end
        PH_ACK: begin
          if (scl_fall) begin
            sda_drive_low <= 1'b0;
            bit_cnt       <= '0;
            phase         <= PH_BITS;
          end
        end
        default: ;
      endcase
    end
  end

  // committed capture fields and sticky flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_dev_addr <= '0;
      cap_cmd_lsb  <= 1'b0;
      cap_ext_byte <= '0;
      cap_data     <= '0;
      hs_sts       <= 1'b0;
      snp_sts      <= 1'b0;
    end else begin
      if (hs_set) begin
        cap_dev_addr <= tmp_dev;
        cap_cmd_lsb  <= tmp_lsb;
        cap_data     <= {tmp_hi, tmp_lo};
        if (ten) cap_ext_byte <= tmp_ext;
      end
      hs_sts  <= hs_set  | (hs_sts  & ~hs_sts_clr);
      snp_sts <= snp_set | (snp_sts & ~snp_sts_clr);
    end
  end

  // R12
  ack_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_drive_low |-> claim);
  // R12
  ack_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_drive_low |-> phase == PH_ACK);
  // R7
  hs_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_sts) |-> $past(stop_evt));
  // R7
  cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(stop_evt) |-> $stable(cap_data) && $stable(cap_dev_addr));
  // R8
  snp_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(snp_sts) |-> $past(stop_evt));
  // R11
  sts_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hs_sts) |-> $past(hs_sts_clr));
endmodule

// File: rtl/smb_notify_rx.sv
module smb_notify_rx
  import smb_notify_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_TAPS   = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                scl_i,
  input  logic                sda_i,
  output logic                sda_drive_low,
  input  logic [ADDR_W-1:0]   hs_addr,
  input  logic [ADDR_W-1:0]   snoop_addr,
  input  logic                hs_sts_clr,
  input  logic                snp_sts_clr,
  output logic [ADDR_W-1:0]   cap_dev_addr,
  output logic                cap_cmd_lsb,
  output logic [BYTE_W-1:0]   cap_ext_byte,
  output logic [2*BYTE_W-1:0] cap_data,
  output logic                hs_sts,
  output logic                snp_sts
);
  localparam int N_LINES = 2;

  logic [N_LINES-1:0] line_raw, line_clean;
  logic start_evt, stop_evt, scl_rise, scl_fall;

  assign line_raw = {scl_i, sda_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_filt
    smb_glitch_filter #(.SYNC_STAGES(SYNC_STAGES), .TAPS(FILT_TAPS)) u_filt (
      .clk(clk), .rst_n(rst_n), .raw(line_raw[g]), .clean(line_clean[g])
    );
  end

  smb_bus_events u_evt (
    .clk(clk), .rst_n(rst_n),
    .scl_f(line_clean[1]), .sda_f(line_clean[0]),
    .start_evt(start_evt), .stop_evt(stop_evt),
    .scl_rise(scl_rise), .scl_fall(scl_fall)
  );

  smb_notify_core u_core (
    .clk(clk), .rst_n(rst_n), .sda_f(line_clean[0]),
    .start_evt(start_evt), .stop_evt(stop_evt),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .hs_addr(hs_addr), .snoop_addr(snoop_addr),
    .hs_sts_clr(hs_sts_clr), .snp_sts_clr(snp_sts_clr),
    .sda_drive_low(sda_drive_low),
    .cap_dev_addr(cap_dev_addr), .cap_cmd_lsb(cap_cmd_lsb),
    .cap_ext_byte(cap_ext_byte), .cap_data(cap_data),
    .hs_sts(hs_sts), .snp_sts(snp_sts)
  );
endmodule

// File: tb/smb_notify_rx_test.sv
module smb_notify_rx_test;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [6:0] hs_addr = 7'b0001000, snoop_addr = 7'b0001000;
  logic hs_sts_clr = 1'b0, snp_sts_clr = 1'b0;
  logic sda_drive_low, cap_cmd_lsb, hs_sts, snp_sts;
  logic [6:0] cap_dev_addr;
  logic [7:0] cap_ext_byte;
  logic [15:0] cap_data;
  logic sda_line;
  int total = 0, bad = 0, cycles = 0;

  always #4 clk = ~clk;
  assign sda_line = sda_m & ~sda_drive_low;

  smb_notify_rx uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_drive_low(sda_drive_low), .hs_addr(hs_addr), .snoop_addr(snoop_addr),
    .hs_sts_clr(hs_sts_clr), .snp_sts_clr(snp_sts_clr),
    .cap_dev_addr(cap_dev_addr), .cap_cmd_lsb(cap_cmd_lsb),
    .cap_ext_byte(cap_ext_byte), .cap_data(cap_data),
    .hs_sts(hs_sts), .snp_sts(snp_sts)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 150000) begin
      bad = bad + 1;
      $display("FAIL watchdog: run did not finish");
      $display("test done: total=%0d bad=%0d", total + 1, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n = 1);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; wq();
    sda_m = 1'b0; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic bus_rstart();
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b0; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b1; wq(2);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq();
      scl_m = 1'b1; wq();
      scl_m = 1'b0; wq();
    end
    sda_m = 1'b1; wq();
    scl_m = 1'b1;
    repeat (Q / 2) @(negedge clk);
    acked = !sda_line;
    repeat (Q / 2) @(negedge clk);
    scl_m = 1'b0; wq();
  endtask

  task automatic pulse_clr(input logic hs, input logic sn);
    @(negedge clk);
    hs_sts_clr = hs; snp_sts_clr = sn;
    @(negedge clk);
    hs_sts_clr = 1'b0; snp_sts_clr = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 dev", cap_dev_addr, 0);
    chk("R1 data", cap_data, 0);
    chk("R1 ext", cap_ext_byte, 0);
    chk("R1 lsb", cap_cmd_lsb, 0);
    chk("R1 flags", {hs_sts, snp_sts}, 0);
    chk("R1 drive", sda_drive_low, 0);
  endtask

  // default addresses equal: notify captured, snoop suppressed
  task automatic t_basic();
    logic a;
    bus_start();
    send_byte({7'h08, 1'b0}, a); chk("R2 addr ack", a, 1);
    send_byte({7'h2A, 1'b1}, a); chk("R2 cmd ack", a, 1);
    send_byte(8'h34, a);         chk("R2 lo ack", a, 1);
    send_byte(8'h12, a);         chk("R2 hi ack", a, 1);
    chk("R7 no flag before stop", hs_sts, 0);
    chk("R7 data held before stop", cap_data, 0);
    bus_stop();
    chk("R7 flag", hs_sts, 1);
    chk("R4 dev", cap_dev_addr, 7'h2A);
    chk("R4 lsb", cap_cmd_lsb, 1);
    chk("R6 data", cap_data, 16'h1234);
    chk("R5 ext unchanged", cap_ext_byte, 0);
    chk("R9 snoop suppressed", snp_sts, 0);
    chk("R12 released", sda_drive_low, 0);
  endtask

  task automatic t_clear();
    pulse_clr(1'b1, 1'b0);
    chk("R11 hs cleared", hs_sts, 0);
  endtask

  task automatic t_ten();
    logic a;
    snoop_addr = 7'h50;
    bus_start();
    send_byte({7'h08, 1'b0}, a);
    send_byte({7'b1111001, 1'b0}, a);
    send_byte(8'hA5, a); chk("R5 ext ack", a, 1);
    send_byte(8'h78, a);
    send_byte(8'h56, a); chk("R2 last ack", a, 1);
    bus_stop();
    chk("R7 flag 10b", hs_sts, 1);
    chk("R4 dev 10b", cap_dev_addr, 7'h79);
    chk("R4 lsb 10b", cap_cmd_lsb, 0);
    chk("R5 ext", cap_ext_byte, 8'hA5);
    chk("R6 data 10b", cap_data, 16'h5678);
    chk("R8 no snoop", snp_sts, 0);
    pulse_clr(1'b1, 1'b0);
  endtask

  task automatic t_read();
    logic a;
    bus_start();
    send_byte({7'h08, 1'b1}, a); chk("R3 read nack", a, 0);
    bus_stop();
    chk("R3 read no flag", hs_sts, 0);
    chk("R3 read data kept", cap_data, 16'h5678);
  endtask

  task automatic t_other();
    logic a;
    bus_start();
    send_byte({7'h11, 1'b0}, a); chk("R3 other nack", a, 0);
    bus_stop();
    chk("R3 other flags", {hs_sts, snp_sts}, 0);
  endtask

  task automatic t_snoop();
    logic a;
    bus_start();
    send_byte({7'h50, 1'b0}, a); chk("R8 snoop write nack", a, 0);
    bus_stop();
    chk("R8 snoop write flag", snp_sts, 1);
    chk("R8 hs untouched", hs_sts, 0);
    pulse_clr(1'b0, 1'b1);
    chk("R11 snp cleared", snp_sts, 0);
    bus_start();
    send_byte({7'h50, 1'b1}, a); chk("R8 snoop read nack", a, 0);
    bus_stop();
    chk("R8 snoop read flag", snp_sts, 1);
    pulse_clr(1'b0, 1'b1);
  endtask

  task automatic t_abort();
    logic a;
    bus_start();
    send_byte({7'h08, 1'b0}, a);
    send_byte({7'h22, 1'b0}, a);
    send_byte(8'h99, a);
    bus_rstart();
    send_byte({7'h33, 1'b0}, a);
    bus_stop();
    chk("R10 rstart no flag", hs_sts, 0);
    chk("R10 rstart data kept", cap_data, 16'h5678);
    chk("R10 rstart dev kept", cap_dev_addr, 7'h79);
    bus_start();
    send_byte({7'h08, 1'b0}, a);
    send_byte({7'h22, 1'b0}, a);
    bus_stop();
    chk("R10 short no flag", hs_sts, 0);
    chk("R10 short dev kept", cap_dev_addr, 7'h79);
  endtask

  task automatic t_newaddr();
    logic a;
    hs_addr = 7'h3C;
    bus_start();
    send_byte({7'h3C, 1'b0}, a); chk("R2 new addr ack", a, 1);
    send_byte({7'h11, 1'b0}, a);
    send_byte(8'hEF, a);
    send_byte(8'hBE, a);
    bus_stop();
    chk("R7 new flag", hs_sts, 1);
    chk("R4 new dev", cap_dev_addr, 7'h11);
    chk("R6 new data", cap_data, 16'hBEEF);
    chk("R5 ext kept", cap_ext_byte, 8'hA5);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_basic();
    t_clear();
    t_ten();
    t_read();
    t_other();
    t_snoop();
    t_abort();
    t_newaddr();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule